// File: doc/BRIEF.md
# Cascadable Serial Command Receiver

This block takes 16-bit command words from a three-wire serial link (data, clock, load) and stores them in a small register file that configures a multiplexed LED display scanner. It holds eight 8-bit digit entries and five control values: a per-digit decode enable, a 4-bit brightness level, the index of the last scanned digit, a shutdown flag and a lamp-test flag. These are presented in parallel to the scanner, which lies outside this block.

The serial clock, data and load lines are treated as slow signals. Each passes through a two-flop synchroniser in the system clock domain, and edges are found there, so the system clock must run at least four times faster than the serial clock. Every shifted bit also travels through a 17-stage chain to a serial output that changes after falling serial clock edges. Several receivers can therefore be daisy-chained on one shared load line. A word sent to the no-op address lets a device in the chain leave its registers untouched while other devices take their own words.

A build-time parameter selects the load line's role. In plain-load mode, shifting ignores the line. In chip-select mode, the line acts as an active-low select that gates the clock.

Top module: `cmd_word_receiver`

## Requirements
- R1: A word is 16 bits sent most significant bit first. The last 16 bits shifted form the word: bits 11:8 are the address, bits 7:0 are the data, and bits 15:12 have no effect.
- R2: In plain-load mode a bit is shifted in on every rising serial clock edge, whatever the load level. When more than 16 bits are sent before a commit, only the last 16 count.
- R3: The register file changes only on a rising edge of the load line, which commits the current word. Words that are shifted but never committed change no output.
- R4: `serOut` changes only after a falling serial clock edge. After the falling edge that follows rising edge n+16, it shows the bit taken in at rising edge n. It is 0 after reset.
- R5: Address 1 to 8 writes digit 0 to 7, held in `digitData[8*i+7:8*i]`. Address 9 writes `decodeSel` (data bits 7:0). Address 0xA writes `brightness` (data bits 3:0). Address 0xB writes `scanLast` (data bits 2:0).
- R6: A commit to address 0, 0xD or 0xE changes no register.
- R7: Address 0xC sets `shutdownOn` to the inverse of data bit 0. Address 0xF sets `testOn` to data bit 0.
- R8: Reset leaves all digits and `decodeSel` at 0, `brightness` at 0, `scanLast` at 0, `shutdownOn` at 1 and `testOn` at 0.
- R9: In chip-select mode, serial clock edges are ignored while the select line is high, and a commit happens on the rising edge of select.
- R10: Words are accepted and committed normally while `shutdownOn` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial clock, asynchronous |
| serData | input | 1 | Serial data in |
| serLoad | input | 1 | Load strobe, or active-low select in chip-select mode |
| serOut | output | 1 | Daisy-chain serial data out |
| digitData | output | 64 | Eight digit registers, digit i at bits 8*i+7:8*i |
| decodeSel | output | 8 | Per-digit decode enable |
| brightness | output | 4 | Brightness level |
| scanLast | output | 3 | Index of the last scanned digit |
| shutdownOn | output | 1 | Display blanked |
| testOn | output | 1 | Lamp test active |

## Verification
The assertions rely on a few properties of the serial inputs. Each level on the serial clock, data and load lines must last at least two system clock cycles. Data must be stable around each rising serial clock edge. Load must not rise in the same cycle as a serial clock edge.

The bench keeps within these limits with a fixed pattern. Each serial half period lasts eight system cycles. Data changes only while the serial clock is low. Load and select move only while the clock is idle low, at least one half period away from any clock edge.

// File: rtl/cmd_rx_pkg.sv
package cmd_rx_pkg;
  localparam int ADDR_W = 4;

  typedef struct packed {
    logic shift;   // take one bit into the chain
    logic drive;   // update the serial output
    logic commit;  // write the held word to the register file
  } rxStrobes_t;

  localparam logic [ADDR_W-1:0] ADDR_NOOP   = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_DECODE = 4'h9;
  localparam logic [ADDR_W-1:0] ADDR_BRIGHT = 4'hA;
  localparam logic [ADDR_W-1:0] ADDR_SCAN   = 4'hB;
  localparam logic [ADDR_W-1:0] ADDR_SHUT   = 4'hC;
  localparam logic [ADDR_W-1:0] ADDR_SPARE0 = 4'hD;
  localparam logic [ADDR_W-1:0] ADDR_SPARE1 = 4'hE;
  localparam logic [ADDR_W-1:0] ADDR_TEST   = 4'hF;
endpackage

// File: rtl/cmd_rx_ctrl.sv
module cmd_rx_ctrl
  import cmd_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit SELECT_MODE = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkIn,
  input  logic       dataIn,
  input  logic       loadIn,
  output rxStrobes_t strobes,
  output logic       dataBit
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sclkSync, dataSync, loadSync;
  logic sclkPrev, loadPrev;
  logic sclkRise, sclkFall, loadRise, clkGate;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      dataSync <= '0;
      loadSync <= '0;
      sclkPrev <= 1'b0;
      loadPrev <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[TOP-1:0], sclkIn};
      dataSync <= {dataSync[TOP-1:0], dataIn};
      loadSync <= {loadSync[TOP-1:0], loadIn};
      sclkPrev <= sclkSync[TOP];
      loadPrev <= loadSync[TOP];
    end
  end

  assign sclkRise = sclkSync[TOP] & ~sclkPrev;
  assign sclkFall = ~sclkSync[TOP] & sclkPrev;
  assign loadRise = loadSync[TOP] & ~loadPrev;

  generate
    if (SELECT_MODE) begin : g_select
      assign clkGate = ~loadSync[TOP];
    end else begin : g_plain
      assign clkGate = 1'b1;
    end
  endgenerate

  assign strobes.shift  = sclkRise & clkGate;
  assign strobes.drive  = sclkFall & clkGate;
  assign strobes.commit = loadRise;
  assign dataBit        = dataSync[TOP];
endmodule

// File: rtl/cmd_rx_datapath.sv
module cmd_rx_datapath
  import cmd_rx_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int DATA_W     = 8,
  parameter int NUM_DIGITS = 8,
  parameter int BRIGHT_W   = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  rxStrobes_t                   strobes,
  input  logic                         dataBit,
  output logic                         serOut,
  output logic [NUM_DIGITS*DATA_W-1:0] digitData,
  output logic [NUM_DIGITS-1:0]        decodeSel,
  output logic [BRIGHT_W-1:0]          brightness,
  output logic [$clog2(NUM_DIGITS)-1:0] scanLast,
  output logic                         shutdownOn,
  output logic                         testOn
);
  localparam int SCAN_W = $clog2(NUM_DIGITS);

  // one stage beyond the word gives the extra serial cycle of delay
  logic [WORD_W:0]          chain;
  logic [ADDR_W-1:0]        addr;
  logic [DATA_W-1:0]        data;
  logic [DATA_W-1:0]        digitMem [NUM_DIGITS];
  logic                     runReg;

  assign addr = chain[DATA_W +: ADDR_W];
  assign data = chain[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain  <= '0;
      serOut <= 1'b0;
    end else begin
      if (strobes.shift) chain  <= {chain[WORD_W-1:0], dataBit};
      if (strobes.drive) serOut <= chain[WORD_W];
    end
  end

  generate
    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) digitMem[i] <= '0;
        else if (strobes.commit && addr == ADDR_W'(i + 1)) digitMem[i] <= data;
      end
      assign digitData[i*DATA_W +: DATA_W] = digitMem[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decodeSel  <= '0;
      brightness <= '0;
      scanLast   <= '0;
      runReg     <= 1'b0;
      testOn     <= 1'b0;
    end else if (strobes.commit) begin
      case (addr)
        ADDR_DECODE: decodeSel  <= data[NUM_DIGITS-1:0];
        ADDR_BRIGHT: brightness <= data[BRIGHT_W-1:0];
        ADDR_SCAN:   scanLast   <= data[SCAN_W-1:0];
        ADDR_SHUT:   runReg     <= data[0];
        ADDR_TEST:   testOn     <= data[0];
        default: ;
      endcase
    end
  end

  assign shutdownOn = ~runReg;

  // R3: the register file moves only on a commit
  assert_regs_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> $stable(digitData) && $stable(decodeSel) && $stable(brightness)
                        && $stable(scanLast) && $stable(shutdownOn) && $stable(testOn));

  // R6: no-op and spare addresses leave every register alone
  assert_ignored_addr_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit && (addr == ADDR_NOOP || addr == ADDR_SPARE0 || addr == ADDR_SPARE1)
    |=> $stable(digitData) && $stable(decodeSel) && $stable(brightness)
        && $stable(scanLast) && $stable(shutdownOn) && $stable(testOn));

  // R4: the serial output moves only after a falling serial clock edge
  assert_out_on_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.drive |=> $stable(serOut));

  // R2: the chain moves only on an accepted rising edge
  assert_chain_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.shift |=> $stable(chain));

  // R7: a shutdown-register commit leaves the flag as the inverse of data bit 0
  assert_shut_polarity_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit && addr == ADDR_SHUT |=> shutdownOn == !$past(data[0]));
endmodule

// File: rtl/cmd_word_receiver.sv
module cmd_word_receiver
  import cmd_rx_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int DATA_W      = 8,
  parameter int NUM_DIGITS  = 8,
  parameter int BRIGHT_W    = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit SELECT_MODE = 1'b0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          serClk,
  input  logic                          serData,
  input  logic                          serLoad,
  output logic                          serOut,
  output logic [NUM_DIGITS*DATA_W-1:0]  digitData,
  output logic [NUM_DIGITS-1:0]         decodeSel,
  output logic [BRIGHT_W-1:0]           brightness,
  output logic [$clog2(NUM_DIGITS)-1:0] scanLast,
  output logic                          shutdownOn,
  output logic                          testOn
);
  rxStrobes_t strobes;
  logic       dataBit;

  cmd_rx_ctrl #(.SYNC_STAGES(SYNC_STAGES), .SELECT_MODE(SELECT_MODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkIn(serClk), .dataIn(serData), .loadIn(serLoad),
    .strobes(strobes), .dataBit(dataBit));

  cmd_rx_datapath #(.WORD_W(WORD_W), .DATA_W(DATA_W), .NUM_DIGITS(NUM_DIGITS),
                    .BRIGHT_W(BRIGHT_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataBit(dataBit), .serOut(serOut),
    .digitData(digitData), .decodeSel(decodeSel), .brightness(brightness),
    .scanLast(scanLast), .shutdownOn(shutdownOn), .testOn(testOn));
endmodule

// File: tb/cmd_word_receiver_test.sv
module cmd_word_receiver_test;
  localparam int H = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, sclk = 1'b0, din = 1'b0, load = 1'b0, sel = 1'b1;

  logic        dout, shutOut, testOut;
  logic [63:0] digOut;
  logic [7:0]  decOut;
  logic [3:0]  briOut;
  logic [2:0]  scanOut;

  logic        doutB, shutB, testB;
  logic [63:0] digB;
  logic [7:0]  decB;
  logic [3:0]  briB;
  logic [2:0]  scanB;

  cmd_word_receiver uut (
    .clk(clk), .rstN(rstN), .serClk(sclk), .serData(din), .serLoad(load), .serOut(dout),
    .digitData(digOut), .decodeSel(decOut), .brightness(briOut), .scanLast(scanOut),
    .shutdownOn(shutOut), .testOn(testOut));

  cmd_word_receiver #(.SELECT_MODE(1'b1)) uutSel (
    .clk(clk), .rstN(rstN), .serClk(sclk), .serData(din), .serLoad(sel), .serOut(doutB),
    .digitData(digB), .decodeSel(decB), .brightness(briB), .scanLast(scanB),
    .shutdownOn(shutB), .testOn(testB));

  int   checks = 0, errors = 0;
  bit   done = 1'b0;
  logic bitQ [$];

  logic [7:0] eDig [8];
  logic [7:0] eDec;
  logic [3:0] eBri;
  logic [2:0] eScan;
  logic       eShut, eTest;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic checkVal(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    logic [63:0] d;
    for (int i = 0; i < 8; i++) d[i*8 +: 8] = eDig[i];
    checkVal(req, {digOut, decOut, briOut, scanOut, shutOut, testOut},
                  {d, eDec, eBri, eScan, eShut, eTest});
  endtask

  // expected register file effect of one committed word
  task automatic model(input logic [15:0] w);
    case (w[11:8])
      4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8: eDig[w[11:8] - 4'h1] = w[7:0];
      4'h9: eDec  = w[7:0];
      4'hA: eBri  = w[3:0];
      4'hB: eScan = w[2:0];
      4'hC: eShut = ~w[0];
      4'hF: eTest = w[0];
      default: ;
    endcase
  endtask

  // driver: every bit sent is pushed as the item expected on serOut later
  task automatic sendBit(input logic b);
    din = b;
    step(H);
    sclk = 1'b1;
    bitQ.push_back(b);
    step(H);
    sclk = 1'b0;
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sendBit(v[i]);
  endtask

  task automatic pulseLoad();
    step(H);
    load = 1'b1;
    step(H);
    load = 1'b0;
    step(H);
  endtask

  task automatic writeWord(input logic [15:0] w);
    sendBits({16'h0, w}, 16);
    pulseLoad();
    model(w);
  endtask

  // monitor: after each falling serial edge, pop the bit sent 16 edges earlier
  always @(negedge sclk) begin
    if (rstN) begin
      step(6);
      if (bitQ.size() > 16) begin
        logic e;
        e = bitQ.pop_front();
        checkVal("R4 serial output delay", {79'h0, dout}, {79'h0, e});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) eDig[i] = 8'h00;
    eDec = 8'h00; eBri = 4'h0; eScan = 3'h0; eShut = 1'b1; eTest = 1'b0;
    step(5);
    rstN = 1'b1;
    step(4);
    checkAll("R8 reset values");
    checkVal("R8 serial output after reset", {79'h0, dout}, 80'h0);

    // R1 R10: junk in bits 15:12, written while shut down
    writeWord(16'hF13C);
    checkAll("R1 R10 digit write during shutdown");

    for (int i = 0; i < 8; i++) begin
      writeWord({4'h0, 4'(i + 1), 8'hA0 + 8'(i * 9)});
      checkAll("R5 digit write");
    end
    writeWord(16'h0955); checkAll("R5 decode select");
    writeWord(16'h0A37); checkAll("R5 brightness low nibble");
    writeWord(16'h0B06); checkAll("R5 scan limit");
    writeWord(16'h0C01); checkAll("R7 leave shutdown");
    writeWord(16'h0F01); checkAll("R7 test on");
    writeWord(16'h0F00); checkAll("R7 test off");
    writeWord(16'h0C00); checkAll("R7 enter shutdown");

    writeWord(16'h00FF); checkAll("R6 no-op address");
    writeWord(16'h0D12); checkAll("R6 spare address D");
    writeWord(16'h0E34); checkAll("R6 spare address E");

    // R2: 24 bits, only the last 16 count
    sendBits(32'h00C30A0C, 24);
    pulseLoad();
    model(16'h0A0C);
    checkAll("R2 overlong word");

    // R2: load held high while shifting has no effect on shifting
    load = 1'b1;
    sendBits(32'h00000B02, 16);
    load = 1'b0;
    pulseLoad();
    model(16'h0B02);
    checkAll("R2 shift with load high");

    // R3: shifted but uncommitted word
    sendBits(32'h00000102, 16);
    step(H);
    checkAll("R3 no commit without load");

    // R9: chip-select instance
    sel = 1'b0;
    step(H);
    sendBits(32'h00000A03, 16);
    step(H);
    sel = 1'b1;
    step(2 * H);
    checkVal("R9 commit on select rise", {76'h0, briB}, {76'h0, 4'h3});
    sendBits(32'h00000A09, 16);
    sel = 1'b0;
    step(H);
    sel = 1'b1;
    step(2 * H);
    checkVal("R9 clock ignored while select high", {76'h0, briB}, {76'h0, 4'h3});
    checkAll("R9 plain instance unchanged without load");

    step(40);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule